// File: doc/BRIEF.md
# Extended I/O Port Decoder

This block sits between a processor's extended 20-bit physical address and a bank of eight small peripheral devices. Each peripheral is given a 16-byte slot, and the block picks which slot an access falls into. It produces a one-hot chip select for that peripheral and passes on the low address nibble as the register index. It also enables the shared I/O data-bus buffers and sets their direction whenever a peripheral is being addressed.

A slot is reachable only through one 512-byte window at the top of physical memory, FE000 to FE1FF. Three things must all hold for an access to land there: all four extension address bits are high, the top logical nibble is E, and logical bits 11 down to 9 are zero. The port number comes from logical bits 6 to 4. Bits 8 and 7 are not looked at, so the bank of eight ports appears four times inside the window. Every output is held in a register and follows the address presented on the previous clock. Nothing is selected on a cycle whose valid-access strobe is low.

Top module: `xio_port_decode`

## Requirements
- R1: While `rst` is high at a rising clock edge, and on the cycle that follows, `port_sel`, `reg_ofs`, `buf_en` and `buf_to_cpu` are all zero.
- R2: One clock after an access, exactly one `port_sel` bit is set when all of these held at that edge: `vma`=1, `addr_ext`=4'hF, `addr_log[15:12]`=4'hE and `addr_log[11:9]`=0. When any of them fails, `port_sel` is all zero.
- R3: The port that is selected is the one whose bit index equals `addr_log[6:4]`. For example, FE050 sets `port_sel[5]`.
- R4: `addr_log[8:7]` have no effect. Addresses that differ only in these two bits give the same `port_sel`, `buf_en` and `buf_to_cpu`.
- R5: `reg_ofs` equals the `addr_log[3:0]` that was presented one clock earlier, whether or not a port is hit.
- R6: `buf_en` is 1 in exactly the cycles in which some `port_sel` bit is 1.
- R7: `buf_to_cpu` is 1 when `buf_en` is 1 and the access one clock earlier was a read (`rd_nwr`=1). It is 0 on writes, and 0 whenever `buf_en` is 0.
- R8: A cycle with `vma`=0 gives all-zero `port_sel` and `buf_en` on the next cycle, for any address.
- R9: At most one `port_sel` bit is ever set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_log | input | 16 | Logical address bits 15..0 |
| addr_ext | input | 4 | Extension address bits (physical bits 19..16) |
| vma | input | 1 | Valid memory access strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| port_sel | output | 8 | One-hot peripheral select, registered |
| reg_ofs | output | 4 | Register index within the slot, registered |
| buf_en | output | 1 | I/O data-buffer enable, registered |
| buf_to_cpu | output | 1 | Buffer direction, 1 = drive toward the processor |

## Verification
A port select and the buffer enable with its direction are raised on the same clock by the same access, so every compared cycle judges the three together. The bench alternates reads and writes to neighbouring slots, and puts window hits right next to misses and idle strobes. This catches a select whose buffer enable or direction lags it or is left over from the previous cycle. The bench also sweeps the four mirror copies of each slot and checks the same select and direction from each copy, against a behavioural model on every cycle.

// File: rtl/xio_pkg.sv
package xio_pkg;

    localparam int LOG_AW  = 16;
    localparam int EXT_W   = 4;
    localparam int PAGE_W  = 4;
    localparam int MIRR_W  = 2;
    localparam int NUM_W   = 3;
    localparam int OFS_W   = 4;
    localparam int GUARD_W = LOG_AW - PAGE_W - MIRR_W - NUM_W - OFS_W;
    localparam int NPORT   = 1 << NUM_W;

    localparam logic [PAGE_W-1:0] IO_PAGE = PAGE_W'(4'hE);

    // logical address split into decode fields, most significant first
    typedef struct packed {
        logic [PAGE_W-1:0]  page;
        logic [GUARD_W-1:0] guard;
        logic [MIRR_W-1:0]  mirror;
        logic [NUM_W-1:0]   num;
        logic [OFS_W-1:0]   ofs;
    } laddr_t;

    typedef struct packed {
        logic             hit;
        logic             rd;
        logic [NUM_W-1:0] num;
    } dec_req_t;

    function automatic laddr_t split_addr(input logic [LOG_AW-1:0] a);
        return laddr_t'(a);
    endfunction

    function automatic logic ext_all_high(input logic [EXT_W-1:0] e);
        return &e;
    endfunction

endpackage

// File: rtl/xio_window.sv
module xio_window
    import xio_pkg::*;
#(
    parameter logic [PAGE_W-1:0] PAGE = IO_PAGE
) (
    input  logic               vma,
    input  logic [EXT_W-1:0]   ext,
    input  logic [PAGE_W-1:0]  page,
    input  logic [GUARD_W-1:0] guard,
    output logic               hit
);

    logic ext_ok;
    logic page_ok;
    logic guard_ok;

    always_comb begin
        ext_ok   = ext_all_high(ext);
        page_ok  = (page == PAGE);
        guard_ok = (guard == '0);
        hit      = vma && ext_ok && page_ok && guard_ok;
    end

endmodule

// File: rtl/xio_sel.sv
module xio_sel
    import xio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vma,
    input  dec_req_t         req,
    output logic [NPORT-1:0] sel
);

    genvar g;
    generate
        for (g = 0; g < NPORT; g++) begin : g_port
            always_ff @(posedge clk) begin
                if (rst) sel[g] <= 1'b0;
                else     sel[g] <= req.hit && (req.num == NUM_W'(g));
            end
        end
    endgenerate

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R9

    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !vma |=> (sel == '0)); // R8

endmodule

// File: rtl/xio_buf.sv
module xio_buf
    import xio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dec_req_t req,
    output logic     en,
    output logic     to_cpu
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            to_cpu <= 1'b0;
        end else begin
            en     <= req.hit;
            to_cpu <= req.hit && req.rd;
        end
    end

    AST_DIR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> !to_cpu); // R7

    AST_WRITE_TOWARD_PERIPH: assert property (@(posedge clk) disable iff (rst)
        (!rst && !req.rd) |=> !to_cpu); // R7

endmodule

// File: rtl/xio_port_decode.sv
module xio_port_decode
    import xio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      addr_log,
    input  logic [3:0]       addr_ext,
    input  logic             vma,
    input  logic             rd_nwr,
    output logic [7:0]       port_sel,
    output logic [3:0]       reg_ofs,
    output logic             buf_en,
    output logic             buf_to_cpu
);

    laddr_t   la;
    logic     win_hit;
    dec_req_t req;
    logic     mirror_unused;

    always_comb begin
        la            = split_addr(addr_log);
        mirror_unused = ^la.mirror;
        req.hit       = win_hit;
        req.rd        = rd_nwr;
        req.num       = la.num;
    end

    xio_window #(.PAGE(IO_PAGE)) i_window (
        .vma   (vma),
        .ext   (addr_ext),
        .page  (la.page),
        .guard (la.guard),
        .hit   (win_hit)
    );

    xio_sel i_sel (
        .clk (clk),
        .rst (rst),
        .vma (vma),
        .req (req),
        .sel (port_sel)
    );

    xio_buf i_buf (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .en     (buf_en),
        .to_cpu (buf_to_cpu)
    );

    always_ff @(posedge clk) begin
        if (rst) reg_ofs <= '0;
        else     reg_ofs <= la.ofs;
    end

    AST_BUF_TRACKS_SEL: assert property (@(posedge clk) disable iff (rst)
        buf_en == (port_sel != '0)); // R6

    AST_OFS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (reg_ofs == $past(addr_log[3:0]))); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (port_sel == '0 && !buf_en && reg_ofs == '0)); // R1

endmodule

// File: tb/test_xio_port_decode.sv
module test_xio_port_decode;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr_log;
    logic [3:0]  addr_ext;
    logic        vma;
    logic        rd_nwr;
    logic [7:0]  port_sel;
    logic [3:0]  reg_ofs;
    logic        buf_en;
    logic        buf_to_cpu;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xio_port_decode i_xio_port_decode (
        .clk        (clk),
        .rst        (rst),
        .addr_log   (addr_log),
        .addr_ext   (addr_ext),
        .vma        (vma),
        .rd_nwr     (rd_nwr),
        .port_sel   (port_sel),
        .reg_ofs    (reg_ofs),
        .buf_en     (buf_en),
        .buf_to_cpu (buf_to_cpu)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference: physical address in window and strobe valid
    function automatic bit ref_hit(input logic [19:0] pa, input logic v);
        int p = int'(pa);
        return v && (p >= 'hFE000) && (p <= 'hFE1FF);
    endfunction

    // drive one access on a falling edge, compare after the next rising edge
    task automatic access(input logic [19:0] pa, input logic v, input logic rd, input string tag);
        bit        h;
        int        exp_sel;
        @(negedge clk);
        addr_ext = pa[19:16];
        addr_log = pa[15:0];
        vma      = v;
        rd_nwr   = rd;
        h        = ref_hit(pa, v);
        exp_sel  = h ? (1 << ((int'(pa) / 16) % 8)) : 0;
        @(negedge clk);
        check({tag, " R2 R3 R9"}, "port_sel", int'(port_sel), exp_sel);
        check("R5", "reg_ofs", int'(reg_ofs), int'(pa) % 16);
        check("R6", "buf_en", int'(buf_en), int'(h));
        check("R7", "buf_to_cpu", int'(buf_to_cpu), int'(h && rd));
    endtask

    initial begin
        while (!finished && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_log = 16'hE050; addr_ext = 4'hF; vma = 1'b1; rd_nwr = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset even with a hitting address applied
        check("R1", "port_sel", int'(port_sel), 0);
        check("R1", "reg_ofs", int'(reg_ofs), 0);
        check("R1", "buf_en", int'(buf_en), 0);
        check("R1", "buf_to_cpu", int'(buf_to_cpu), 0);
        rst = 1'b0;

        // R3: each slot, read then write back to back
        for (int p = 0; p < 8; p++) begin
            access(20'hFE000 + 20'(p * 16 + p), 1'b1, 1'b1, "R3");
            access(20'hFE000 + 20'(p * 16 + 15 - p), 1'b1, 1'b0, "R3");
        end
        // R2: window edges and near misses
        access(20'hFE000, 1'b1, 1'b1, "R2");
        access(20'hFE1FF, 1'b1, 1'b0, "R2");
        access(20'hFE200, 1'b1, 1'b1, "R2");
        access(20'hFDFFF, 1'b1, 1'b1, "R2");
        access(20'h7E050, 1'b1, 1'b1, "R2");
        access(20'hEE050, 1'b1, 1'b1, "R2");
        access(20'hFF050, 1'b1, 1'b1, "R2");
        access(20'hFE850, 1'b1, 1'b1, "R2");
        access(20'h0E050, 1'b1, 1'b1, "R2");
        // R4: four mirror copies of every slot
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 8; p++)
                access(20'hFE000 + 20'(m * 128 + p * 16 + 3), 1'b1, 1'(m % 2), "R4");
        // R8: idle strobe inside window, between hits
        access(20'hFE030, 1'b1, 1'b1, "R8");
        access(20'hFE030, 1'b0, 1'b1, "R8");
        access(20'hFE070, 1'b0, 1'b0, "R8");
        access(20'hFE070, 1'b1, 1'b0, "R8");
        // mixed sweep, half forced into the window
        for (int i = 0; i < 400; i++) begin
            logic [19:0] pa;
            pa = 20'($urandom);
            if (i % 2 == 0) pa = 20'hFE000 | (pa & 20'h001FF);
            access(pa, 1'($urandom % 4 != 0), 1'($urandom), "R2");
        end
        // R1: reset in the middle of a hit
        access(20'hFE020, 1'b1, 1'b1, "R3");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "port_sel", int'(port_sel), 0);
        check("R1", "buf_en", int'(buf_en), 0);
        rst = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule